// File: doc/BRIEF.md
# Bitfield and Logic Execution Unit

This block is the datapath stage of a small command-macro sequencer. Each cycle it may accept one decoded instruction: two 32-bit register operands, a signed immediate, an operation class, an ALU function code and three 5-bit bitfield descriptors (extract offset, insert offset and field size). It computes one 32-bit result combinationally and presents it from an output register one clock later, together with a valid strobe and an unimplemented flag.

The operation classes are:

- an ALU operation on the two operands;
- operand A plus the sign-extended immediate;
- the same sum, used as the address of an external register read;
- three bitfield forms.

The read access itself happens outside the block. The bitfield forms are:

- a plain extract-and-insert;
- an extract whose starting bit comes from operand A;
- an extract whose landing position comes from operand A.

Encodings that this unit does not execute are the carry and borrow ALU variants, any unlisted ALU code and the spare operation classes. For these the unit raises the unimplemented flag and returns zero. The sequencer treats that flag as a fault.

Top module: `bfx_exec_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_data` and `out_unimpl` are all 0.
- R2: An instruction with `in_valid` high at a rising edge produces its result on `out_valid`/`out_data`/`out_unimpl` right after that edge. A cycle with `in_valid` low has the following effects one edge later:
  - `out_valid` is 0;
  - `out_unimpl` is 0;
  - `out_data` keeps its previous value.
- R3: With `in_opc` = 0 (ALU), `in_fn` selects the function:
  - 0: A+B
  - 2: A−B
  - 8: A^B
  - 9: A|B
  - 10: A&B
  - 11: A&~B
  - 12: ~(A&B)

  All results are modulo 2^32.
- R4: With `in_opc` = 1 the result is A plus `in_imm` sign-extended from 18 bits (bit 17 is the sign), modulo 2^32.
- R5: With `in_opc` = 5 the result is the read address A + sign-extended `in_imm`, computed the same way as R4.
- R6: With `in_opc` = 2 the field is built and merged as follows:
  - take B shifted right by `in_src_pos` and keep its low `in_fld_size` bits;
  - clear that many bits of A starting at bit `in_dst_pos`;
  - OR the field in at that position.

  Field bits above bit 31 are dropped.
- R7: With `in_opc` = 3 the result is B shifted right by A[4:0], masked to `in_fld_size` bits, then shifted left by `in_dst_pos`. The result bits below `in_dst_pos` are zero.
- R8: With `in_opc` = 4 the result is B shifted right by `in_src_pos`, masked to `in_fld_size` bits, then shifted left by A[4:0].
- R9: A field size of 0 is an empty field. In that case opcode 2 returns A unchanged, and opcodes 3 and 4 return 0.
- R10: The following encodings set `out_unimpl` to 1 and `out_data` to 0:
  - `in_opc` = 0 with `in_fn` = 1 (add with carry) or 3 (subtract with borrow);
  - `in_opc` = 0 with any `in_fn` not listed in R3;
  - `in_opc` = 6 or 7.

  Every other encoding sets `out_unimpl` to 0.
- R11: Register-sourced shift amounts use only A[4:0]. Bits 31:5 of A do not change the results of opcodes 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_opc | input | 3 | Operation class |
| in_fn | input | 5 | ALU function code (used when `in_opc` = 0) |
| in_a | input | 32 | Operand A |
| in_b | input | 32 | Operand B |
| in_imm | input | 18 | Signed immediate |
| in_src_pos | input | 5 | Extract offset |
| in_dst_pos | input | 5 | Insert offset |
| in_fld_size | input | 5 | Field width in bits |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | 32 | Registered result |
| out_unimpl | output | 1 | Encoding not executed |

## Verification
Every result is due exactly one rising edge after the cycle that carries `in_valid`, because one output register lies between the inputs and the ports. The bench therefore drives each instruction on a falling edge and reads the outputs on the next falling edge, half a period after the capturing edge. It compares them with a model that builds each bitfield result bit by bit. Hold behaviour is checked by dropping `in_valid` and changing operands, then reading one falling edge later. That check confirms that `out_data` is unchanged and that the strobe is low.

// File: rtl/bfx_exec_pkg.sv
package bfx_exec_pkg;

    typedef enum logic [2:0] {
        OPC_ALU      = 3'd0,
        OPC_ADDI     = 3'd1,
        OPC_XINS     = 3'd2,
        OPC_XSHL_IMM = 3'd3,
        OPC_XSHL_REG = 3'd4,
        OPC_RADDR    = 3'd5
    } bfx_opc_e;

    typedef enum logic [4:0] {
        FN_ADD  = 5'd0,
        FN_ADDC = 5'd1,
        FN_SUB  = 5'd2,
        FN_SUBB = 5'd3,
        FN_XOR  = 5'd8,
        FN_OR   = 5'd9,
        FN_AND  = 5'd10,
        FN_ANDN = 5'd11,
        FN_NAND = 5'd12
    } bfx_fn_e;

endpackage

// File: rtl/bfx_logic_unit.sv
module bfx_logic_unit
    import bfx_exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FN_W   = 5
) (
    input  logic [FN_W-1:0]   fn,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] res,
    output logic              unimpl
);

    always_comb begin
        res    = '0;
        unimpl = 1'b0;
        case (fn)
            FN_ADD:  res = opa + opb;
            FN_SUB:  res = opa - opb;
            FN_XOR:  res = opa ^ opb;
            FN_OR:   res = opa | opb;
            FN_AND:  res = opa & opb;
            FN_ANDN: res = opa & ~opb;
            FN_NAND: res = ~(opa & opb);
            default: begin
                // carry/borrow variants and spare codes
                res    = '0;
                unimpl = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/bfx_offset_adder.sv
module bfx_offset_adder #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 18
) (
    input  logic [DATA_W-1:0] base,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] sum
);

    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    assign sum     = base + imm_ext;

endmodule

// File: rtl/bfx_bitfield_unit.sv
module bfx_bitfield_unit #(
    parameter int DATA_W = 32,
    parameter int POS_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [POS_W-1:0]  src_pos,
    input  logic [POS_W-1:0]  dst_pos,
    input  logic [POS_W-1:0]  fld_size,
    output logic [DATA_W-1:0] ins_res,
    output logic [DATA_W-1:0] xshl_imm_res,
    output logic [DATA_W-1:0] xshl_reg_res
);

    localparam int CMP_W = POS_W + 1;

    logic [DATA_W-1:0] fld_mask;
    logic [POS_W-1:0]  reg_amt;
    logic [DATA_W-1:0] src_imm_field;
    logic [DATA_W-1:0] src_reg_field;

    // one mask bit per position: set below the field size
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
        assign fld_mask[gi] = ({1'b0, fld_size} > CMP_W'(gi));
    end

    // register-sourced amounts use the low POS_W bits only
    assign reg_amt = opa[POS_W-1:0];

    assign src_imm_field = (opb >> src_pos) & fld_mask;
    assign src_reg_field = (opb >> reg_amt) & fld_mask;

    assign ins_res      = (opa & ~(fld_mask << dst_pos)) | (src_imm_field << dst_pos);
    assign xshl_imm_res = src_reg_field << dst_pos;
    assign xshl_reg_res = src_imm_field << reg_amt;

    AST_EMPTY_FIELD_KEEPS_A: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_size == '0) |-> (ins_res == opa)); // R9
    AST_EMPTY_FIELD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_size == '0) |-> (xshl_imm_res == '0 && xshl_reg_res == '0)); // R9
    AST_LOW_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((xshl_imm_res << (DATA_W - int'(dst_pos))) == '0)); // R7

endmodule

// File: rtl/bfx_exec_unit.sv
module bfx_exec_unit
    import bfx_exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 18,
    parameter int OPC_W  = 3,
    parameter int FN_W   = 5,
    localparam int POS_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OPC_W-1:0]  in_opc,
    input  logic [FN_W-1:0]   in_fn,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic [IMM_W-1:0]  in_imm,
    input  logic [POS_W-1:0]  in_src_pos,
    input  logic [POS_W-1:0]  in_dst_pos,
    input  logic [POS_W-1:0]  in_fld_size,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_unimpl
);

    logic [DATA_W-1:0] alu_res;
    logic              alu_unimpl;
    logic [DATA_W-1:0] off_sum;
    logic [DATA_W-1:0] ins_res;
    logic [DATA_W-1:0] xshl_imm_res;
    logic [DATA_W-1:0] xshl_reg_res;
    logic [DATA_W-1:0] nxt_data;
    logic              nxt_unimpl;

    bfx_logic_unit #(
        .DATA_W (DATA_W),
        .FN_W   (FN_W)
    ) logic_i (
        .fn     (in_fn),
        .opa    (in_a),
        .opb    (in_b),
        .res    (alu_res),
        .unimpl (alu_unimpl)
    );

    // one adder serves both add-immediate and the read address
    bfx_offset_adder #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W)
    ) offs_i (
        .base (in_a),
        .imm  (in_imm),
        .sum  (off_sum)
    );

    bfx_bitfield_unit #(
        .DATA_W (DATA_W),
        .POS_W  (POS_W)
    ) bitf_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .opa          (in_a),
        .opb          (in_b),
        .src_pos      (in_src_pos),
        .dst_pos      (in_dst_pos),
        .fld_size     (in_fld_size),
        .ins_res      (ins_res),
        .xshl_imm_res (xshl_imm_res),
        .xshl_reg_res (xshl_reg_res)
    );

    // result select
    always_comb begin
        nxt_data   = '0;
        nxt_unimpl = 1'b0;
        unique case (in_opc)
            OPC_ALU: begin
                nxt_data   = alu_res;
                nxt_unimpl = alu_unimpl;
            end
            OPC_ADDI,
            OPC_RADDR:    nxt_data = off_sum;
            OPC_XINS:     nxt_data = ins_res;
            OPC_XSHL_IMM: nxt_data = xshl_imm_res;
            OPC_XSHL_REG: nxt_data = xshl_reg_res;
            default: begin
                nxt_data   = '0;
                nxt_unimpl = 1'b1;
            end
        endcase
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_unimpl <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data   <= nxt_data;
                out_unimpl <= nxt_unimpl;
            end else begin
                out_unimpl <= 1'b0;
            end
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_unimpl)); // R2
    AST_IDLE_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data)); // R2
    AST_UNIMPL_RETURNS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_unimpl |-> (out_valid && out_data == '0)); // R10
    AST_CARRY_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_opc == OPC_ALU && (in_fn == FN_ADDC || in_fn == FN_SUBB))
        |=> out_unimpl); // R10
    AST_ADDI_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_opc == OPC_ADDI) |=>
        (out_data == $past(in_a) + DATA_W'($signed($past(in_imm))))); // R4

endmodule

// File: tb/bfx_exec_unit_tb_top.sv
module bfx_exec_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [2:0]  in_opc;
    logic [4:0]  in_fn;
    logic [31:0] in_a;
    logic [31:0] in_b;
    logic [17:0] in_imm;
    logic [4:0]  in_src_pos;
    logic [4:0]  in_dst_pos;
    logic [4:0]  in_fld_size;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_unimpl;

    int checks = 0;
    int errors = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    bfx_exec_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_opc      (in_opc),
        .in_fn       (in_fn),
        .in_a        (in_a),
        .in_b        (in_b),
        .in_imm      (in_imm),
        .in_src_pos  (in_src_pos),
        .in_dst_pos  (in_dst_pos),
        .in_fld_size (in_fld_size),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_unimpl  (out_unimpl)
    );

    function automatic logic [31:0] rnd();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // bit-by-bit model of the three bitfield forms: 0 insert, 1 reg extract, 2 reg insert
    function automatic logic [31:0] bf_model(int form, logic [31:0] a, logic [31:0] b,
                                              int src, int dst, int size);
        logic [31:0] r;
        int ex_off;
        int in_off;
        r      = (form == 0) ? a : 32'h0;
        ex_off = (form == 1) ? int'(a[4:0]) : src;
        in_off = (form == 2) ? int'(a[4:0]) : dst;
        for (int i = 0; i < 32; i++) begin
            if (i >= in_off && i < in_off + size) begin
                int j = ex_off + i - in_off;
                r[i] = (j < 32) ? b[j] : 1'b0;
            end
        end
        return r;
    endfunction

    task automatic run(string tag, logic [2:0] opc, logic [4:0] fn, logic [31:0] a,
                       logic [31:0] b, logic [17:0] imm, logic [4:0] sp, logic [4:0] dp,
                       logic [4:0] sz, logic [31:0] exp_d, logic exp_u);
        in_valid    = 1'b1;
        in_opc      = opc;
        in_fn       = fn;
        in_a        = a;
        in_b        = b;
        in_imm      = imm;
        in_src_pos  = sp;
        in_dst_pos  = dp;
        in_fld_size = sz;
        @(posedge clk);
        @(negedge clk);
        chk({tag, " valid"}, {31'h0, out_valid}, 32'h1);
        chk({tag, " data"}, out_data, exp_d);
        chk({tag, " unimpl"}, {31'h0, out_unimpl}, {31'h0, exp_u});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired got running expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] e;
        logic        u;
        int          sizes [5] = '{0, 1, 7, 16, 31};
        rst_n = 1'b0; in_valid = 1'b0; in_opc = '0; in_fn = '0; in_a = '0; in_b = '0;
        in_imm = '0; in_src_pos = '0; in_dst_pos = '0; in_fld_size = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 valid", {31'h0, out_valid}, 32'h0);
        chk("R1 data", out_data, 32'h0);
        chk("R1 unimpl", {31'h0, out_unimpl}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 / R10 ALU sweep over all function codes
        for (int f = 0; f < 32; f++) begin
            for (int k = 0; k < 8; k++) begin
                a = (k == 0) ? 32'h0 : (k == 1) ? 32'hffff_ffff : rnd();
                b = (k == 0) ? 32'h0 : (k == 1) ? 32'h1 : rnd();
                u = 1'b0;
                case (f)
                    0:  e = a + b;
                    2:  e = a - b;
                    8:  e = a ^ b;
                    9:  e = a | b;
                    10: e = a & b;
                    11: e = a & ~b;
                    12: e = ~(a & b);
                    default: begin e = 32'h0; u = 1'b1; end
                endcase
                run(u ? "R10 alu" : "R3 alu", 3'd0, 5'(f), a, b, 18'(rnd()), 5'd0, 5'd0,
                    5'd0, e, u);
            end
        end

        // R10 spare operation classes
        for (int o = 6; o < 8; o++) begin
            for (int k = 0; k < 4; k++)
                run("R10 spare opc", 3'(o), 5'd0, rnd(), rnd(), 18'(rnd()), 5'd3, 5'd4,
                    5'd5, 32'h0, 1'b1);
        end

        // R4 add-immediate and R5 read address
        for (int k = 0; k < 24; k++) begin
            logic [17:0] im;
            int          iv;
            im = (k == 0) ? 18'h0 : (k == 1) ? 18'h1ffff : (k == 2) ? 18'h20000 :
                 (k == 3) ? 18'h3ffff : 18'(rnd());
            iv = im[17] ? int'(im) - 262144 : int'(im);
            a  = (k == 4) ? 32'hffff_ffff : rnd();
            e  = a + 32'(iv);
            run("R4 addi", 3'd1, 5'(rnd()), a, rnd(), im, 5'(rnd()), 5'(rnd()), 5'(rnd()),
                e, 1'b0);
            run("R5 read addr", 3'd5, 5'(rnd()), a, rnd(), im, 5'(rnd()), 5'(rnd()),
                5'(rnd()), e, 1'b0);
        end

        // R6 / R9 extract-insert
        for (int s = 0; s < 32; s++)
            for (int d = 0; d < 32; d++)
                foreach (sizes[z]) begin
                    a = rnd(); b = rnd();
                    run(sizes[z] == 0 ? "R9 xins" : "R6 xins", 3'd2, 5'd0, a, b, 18'd0,
                        5'(s), 5'(d), 5'(sizes[z]), bf_model(0, a, b, s, d, sizes[z]), 1'b0);
                end

        // R7 / R9 / R11 extract by register, insert by immediate
        for (int s = 0; s < 32; s++)
            for (int d = 0; d < 32; d++)
                foreach (sizes[z]) begin
                    a = {rnd() & 32'hffff_ffe0} | 32'(s); b = rnd();
                    run(sizes[z] == 0 ? "R9 xshl imm" : "R7 R11 xshl imm", 3'd3, 5'd0, a, b,
                        18'd0, 5'(rnd()), 5'(d), 5'(sizes[z]),
                        bf_model(1, 32'(s), b, 0, d, sizes[z]), 1'b0);
                end

        // R8 / R9 / R11 extract by immediate, insert by register
        for (int s = 0; s < 32; s++)
            for (int d = 0; d < 32; d++)
                foreach (sizes[z]) begin
                    a = {rnd() & 32'hffff_ffe0} | 32'(d); b = rnd();
                    run(sizes[z] == 0 ? "R9 xshl reg" : "R8 R11 xshl reg", 3'd4, 5'd0, a, b,
                        18'd0, 5'(s), 5'(rnd()), 5'(sizes[z]),
                        bf_model(2, 32'(d), b, s, 0, sizes[z]), 1'b0);
                end

        // R11 explicit: upper bits of A only, same low bits
        for (int k = 0; k < 16; k++) begin
            b = rnd();
            run("R11 upper A xshl imm", 3'd3, 5'd0, 32'hffff_ffe0 | 32'(k), b, 18'd0, 5'd0,
                5'd2, 5'd9, bf_model(1, 32'(k), b, 0, 2, 9), 1'b0);
            run("R11 upper A xshl reg", 3'd4, 5'd0, 32'h8000_0020 | 32'(k), b, 18'd0, 5'd3,
                5'd0, 5'd9, bf_model(2, 32'(k), b, 3, 0, 9), 1'b0);
        end

        // R2 hold while idle, after a normal and after an unimplemented result
        for (int k = 0; k < 4; k++) begin
            a = rnd(); b = rnd();
            u = (k % 2 == 1);
            run("R2 setup", 3'd0, u ? 5'd3 : 5'd9, a, b, 18'd0, 5'd0, 5'd0, 5'd0,
                u ? 32'h0 : (a | b), u);
            e = out_data;
            in_valid = 1'b0;
            in_a     = rnd();
            in_fn    = 5'd1;
            @(posedge clk);
            @(negedge clk);
            chk("R2 idle valid", {31'h0, out_valid}, 32'h0);
            chk("R2 idle data", out_data, e);
            chk("R2 idle unimpl", {31'h0, out_unimpl}, 32'h0);
        end

        in_valid = 1'b0;
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule